// File: doc/BRIEF.md
# Nibble-Decomposed Parallel Multiplier

This block multiplies two unsigned 8-bit operands into a 16-bit product. Each operand is cut into a high and a low 4-bit nibble. Four small lookup tables then form the four nibble-by-nibble partial products at the same time. Each partial product carries a weight that is a power of sixteen. A narrow middle adder and a wider upper adder sum the partial products into the result.

A build-time parameter picks one of two variants. The first is purely combinational: the product and its valid flag follow the inputs in the same cycle. The second is a three-stage registered pipeline. Its stages are the partial products, the middle sum and the upper sum. It accepts a new operand pair on every clock, and the valid flag moves through it in step with the data.

Top module: `nibmul_par`

## Requirements
- R1: `out_prod` equals the unsigned product `in_a * in_b` for every operand pair. In pipelined mode, the pair is the one presented three clocks earlier.
- R2: Each partial product is read from a table that holds, at index {first nibble, second nibble}, the 8-bit product of the two nibbles. Operands below 16 therefore give a product equal to the low-nibble product alone.
- R3: Product bits [3:0] equal bits [3:0] of the low-by-low nibble product. No adder lies in that path.
- R4: The 12-bit upper sum that forms product bits [15:4] never carries out. The largest case, 0xFF * 0xFF, gives 0xFE01.
- R5: With `PIPELINED`=1, `out_valid` and `out_prod` for a pair sampled at clock edge k are visible after edge k+2. A pair can enter on every edge, so two back-to-back pairs finish within four clocks.
- R6: With `PIPELINED`=0, `out_prod` and `out_valid` depend only on the current inputs, and `out_valid` equals `in_valid`.
- R7: With `PIPELINED`=1, a clock edge that sees `rst_n` low clears every stage. After that edge `out_valid` is 0 and `out_prod` is 0, and pairs that were in flight are dropped.
- R8: Data advances through the pipeline whether `in_valid` is high or low. A pair sent with `in_valid` low still yields its correct product three clocks later, with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (pipelined variant) |
| rst_n | input | 1 | Synchronous reset, active low |
| in_a | input | 8 | Multiplicand |
| in_b | input | 8 | Multiplier |
| in_valid | input | 1 | Marks the operand pair as valid |
| out_prod | output | 16 | Unsigned product |
| out_valid | output | 1 | Marks `out_prod` as valid |

## Verification
In the pipelined variant, a new operand pair enters stage one on the same edge that an older pair's product retires from stage three. The bench drives pairs on every clock through all 65,536 combinations, with `in_valid` toggling. At each cycle it compares the output against a three-deep model of expected products and valid bits that it keeps for itself. A reset is also applied while operands are still in flight, with valid inputs held during it. The bench checks that the dropped pairs never come out and that the pair held during the release cycle emerges on time.

// File: rtl/nibmul_pkg.sv
package nibmul_pkg;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 2 * NIB_W;
    localparam int PP_W   = 2 * NIB_W;
    localparam int MID_W  = PP_W + 1;
    localparam int HI_W   = 3 * NIB_W;
    localparam int PROD_W = 4 * NIB_W;
    localparam int N_PP   = 4;

    typedef logic [PP_W-1:0] pp_t;

    typedef struct packed {
        logic              v1;
        pp_t               r1;
        pp_t               s1;
        pp_t               t1;
        pp_t               u1;
        logic              v2;
        pp_t               r2;
        pp_t               u2;
        logic [MID_W-1:0]  m2;
        logic              v3;
        logic [PROD_W-1:0] p3;
    } pipe_t;
endpackage

// File: rtl/nibmul_lut.sv
module nibmul_lut #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int N = 1 << (2 * W);
    localparam int MASK = (1 << W) - 1;

    function automatic logic [2*W-1:0] entry(input int idx);
        int hi;
        int lo;
        hi = idx >> W;
        lo = idx & MASK;
        return (2*W)'(hi * lo);
    endfunction

    logic [2*W-1:0] tbl [N];

    for (genvar i = 0; i < N; i++) begin : g_fill
        assign tbl[i] = entry(i);
    end

    assign p = tbl[{a, b}];

    // R2: table content matches a direct nibble product
    always_comb begin
        p_lut_entry_r2: assert (p == ({{W{1'b0}}, a} * {{W{1'b0}}, b}));
    end
endmodule

// File: rtl/nibmul_pp4.sv
module nibmul_pp4
    import nibmul_pkg::*;
(
    input  logic [OP_W-1:0] x,
    input  logic [OP_W-1:0] y,
    output pp_t             pp [N_PP]
);
    // index 0: xlo*ylo, 1: xlo*yhi, 2: xhi*ylo, 3: xhi*yhi
    for (genvar k = 0; k < N_PP; k++) begin : g_pp
        logic [NIB_W-1:0] a_sel;
        logic [NIB_W-1:0] b_sel;
        assign a_sel = (k / 2 == 1) ? x[OP_W-1:NIB_W] : x[NIB_W-1:0];
        assign b_sel = (k % 2 == 1) ? y[OP_W-1:NIB_W] : y[NIB_W-1:0];
        nibmul_lut #(.W(NIB_W)) lut_i (
            .a (a_sel),
            .b (b_sel),
            .p (pp[k])
        );
    end
endmodule

// File: rtl/nibmul_par.sv
module nibmul_par
    import nibmul_pkg::*;
#(
    parameter bit PIPELINED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   in_a,
    input  logic [OP_W-1:0]   in_b,
    input  logic              in_valid,
    output logic [PROD_W-1:0] out_prod,
    output logic              out_valid
);
    pp_t pp [N_PP];

    nibmul_pp4 pp_i (
        .x  (in_a),
        .y  (in_b),
        .pp (pp)
    );

    if (PIPELINED) begin : g_pipe
        pipe_t pipe_d;
        pipe_t pipe_q;
        logic [HI_W:0] hi_sum;
        logic [1:0]    age_q;

        always_comb begin
            pipe_d    = pipe_q;
            // stage 1: partial products
            pipe_d.v1 = in_valid;
            pipe_d.r1 = pp[0];
            pipe_d.s1 = pp[1];
            pipe_d.t1 = pp[2];
            pipe_d.u1 = pp[3];
            // stage 2: middle-weight sum
            pipe_d.v2 = pipe_q.v1;
            pipe_d.r2 = pipe_q.r1;
            pipe_d.u2 = pipe_q.u1;
            pipe_d.m2 = {1'b0, pipe_q.s1} + {1'b0, pipe_q.t1};
            // stage 3: upper sum, low nibble passes straight
            hi_sum    = {1'b0, pipe_q.u2, pipe_q.r2[PP_W-1:NIB_W]}
                      + {{(HI_W + 1 - MID_W){1'b0}}, pipe_q.m2};
            pipe_d.v3 = pipe_q.v2;
            pipe_d.p3 = {hi_sum[HI_W-1:0], pipe_q.r2[NIB_W-1:0]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q <= '0;
                age_q  <= '0;
            end else begin
                pipe_q <= pipe_d;
                if (age_q != 2'd3) age_q <= age_q + 2'd1;
            end
        end

        assign out_prod  = pipe_q.p3;
        assign out_valid = pipe_q.v3;

        p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !hi_sum[HI_W]);
        p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));
        p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3) |-> (out_prod ==
                ({{NIB_W{1'b0}}, NIB_W'(0), $past(in_a, 3)} *
                 {{NIB_W{1'b0}}, NIB_W'(0), $past(in_b, 3)})));
        p_reset_clear_r7: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && out_prod == '0));
    end else begin : g_comb
        logic [MID_W-1:0] mid_c;
        logic [HI_W:0]    hi_c;

        always_comb begin
            mid_c     = {1'b0, pp[1]} + {1'b0, pp[2]};
            hi_c      = {1'b0, pp[3], pp[0][PP_W-1:NIB_W]}
                      + {{(HI_W + 1 - MID_W){1'b0}}, mid_c};
            out_prod  = {hi_c[HI_W-1:0], pp[0][NIB_W-1:0]};
            out_valid = in_valid;
        end

        always_comb begin
            p_comb_prod_r1: assert (out_prod ==
                ({{OP_W{1'b0}}, in_a} * {{OP_W{1'b0}}, in_b}));
            p_comb_carry_r4: assert (!hi_c[HI_W]);
        end
    end
endmodule

// File: tb/nibmul_par_tb.sv
module nibmul_par_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a = '0;
    logic [7:0]  b = '0;
    logic        v = 1'b0;
    logic [15:0] p_prod;
    logic        p_vld;
    logic [15:0] c_prod;
    logic        c_vld;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [15:0] hx [3];
    logic        hv [3];

    // vector: {a, b, expected product}
    localparam logic [31:0] VEC [12] = '{
        {8'hff, 8'hff, 16'hfe01}, {8'hff, 8'h01, 16'h00ff},
        {8'h01, 8'hff, 16'h00ff}, {8'h10, 8'h10, 16'h0100},
        {8'h0f, 8'h0f, 16'h00e1}, {8'hf0, 8'hf0, 16'he100},
        {8'h80, 8'h02, 16'h0100}, {8'h12, 8'h37, 16'h03de},
        {8'h0f, 8'hf0, 16'h0e10}, {8'haa, 8'h55, 16'h3872},
        {8'h7f, 8'h81, 16'h3fff}, {8'h00, 8'ha5, 16'h0000}
    };

    always #5 clk = ~clk;

    nibmul_par #(.PIPELINED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_a(a), .in_b(b), .in_valid(v),
        .out_prod(p_prod), .out_valid(p_vld)
    );

    nibmul_par #(.PIPELINED(1'b0)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .in_a(a), .in_b(b), .in_valid(v),
        .out_prod(c_prod), .out_valid(c_vld)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic hist_clear(input logic [15:0] held, input logic hvld);
        hx[0] = held; hv[0] = hvld;
        for (int i = 1; i < 3; i++) begin
            hx[i] = '0; hv[i] = 1'b0;
        end
    endtask

    task automatic step(input logic [7:0] na, input logic [7:0] nb, input logic nv);
        logic [15:0] e;
        logic [7:0]  lo;
        @(negedge clk);
        // R5: valid three clocks after entry; R1/R8: data always carried
        chk(p_vld == hv[2], "R5", "pipe valid", int'(p_vld), int'(hv[2]));
        chk(p_prod == hx[2], hv[2] ? "R1" : "R8", "pipe product",
            int'(p_prod), int'(hx[2]));
        hx[2] = hx[1]; hv[2] = hv[1];
        hx[1] = hx[0]; hv[1] = hv[0];
        e = 16'(na) * 16'(nb);
        hx[0] = e; hv[0] = nv;
        a = na; b = nb; v = nv;
        #1;
        chk(c_prod == e, "R6", "comb product", int'(c_prod), int'(e));
        chk(c_vld == nv, "R6", "comb valid", int'(c_vld), int'(nv));
        lo = 8'(na[3:0]) * 8'(nb[3:0]);
        chk(c_prod[3:0] == lo[3:0], "R3", "low nibble", int'(c_prod[3:0]),
            int'(lo[3:0]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; a = 8'hff; b = 8'hff; v = 1'b1;
        @(negedge clk);
        chk(p_vld == 1'b0, "R7", "valid after reset", int'(p_vld), 0);
        chk(p_prod == 16'h0, "R7", "product after reset", int'(p_prod), 0);
        rst_n = 1'b1;
        hist_clear(16'hfe01, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        hist_clear(16'h0, 1'b0);
        repeat (2) @(negedge clk);
        chk(p_vld == 1'b0, "R7", "reset state valid", int'(p_vld), 0);
        chk(p_prod == 16'h0, "R7", "reset state product", int'(p_prod), 0);
        rst_n = 1'b1;
        hist_clear(16'h0, 1'b0);

        // table walk, one pair per clock (R1, R2, R4, R5)
        foreach (VEC[i]) begin
            step(VEC[i][31:24], VEC[i][23:16], 1'b1);
            chk(c_prod == VEC[i][15:0],
                (VEC[i][31:24] < 8'h10 && VEC[i][23:16] < 8'h10) ? "R2" :
                (VEC[i][15:0] == 16'hfe01) ? "R4" : "R1",
                "table vector", int'(c_prod), int'(VEC[i][15:0]));
        end
        // invalid pairs still produce data (R8)
        step(8'h3c, 8'h5a, 1'b0);
        step(8'hc3, 8'ha5, 1'b0);
        step(8'h00, 8'h00, 1'b0);
        step(8'h00, 8'h00, 1'b0);
        step(8'h00, 8'h00, 1'b0);

        // reset with pairs in flight (R7)
        step(8'h03, 8'h05, 1'b1);
        step(8'h07, 8'h09, 1'b1);
        do_reset();
        for (int i = 0; i < 4; i++) step(8'h00, 8'h00, 1'b0);

        // exhaustive back-to-back sweep, valid toggling (R1, R5, R8)
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] iv;
            iv = 16'(i);
            step(iv[15:8], iv[7:0], iv[0] ^ iv[8]);
        end
        for (int i = 0; i < 3; i++) step(8'h00, 8'h00, 1'b0);
        report();
    end
endmodule